// File: doc/BRIEF.md
# Twenty-Pin GPIO Expander Register Bank

This core sits behind a byte-serial host link and turns ten byte-wide setting registers into control of twenty general-purpose pins. The host opens a transaction with a start strobe, sends one address byte, then any number of data bytes. Each data byte carries a read/write flag. After each data byte, an internal pointer steps to the next register and wraps around. The registers fall into four kinds: output data latches, interrupt masks, direction selects and one control register. The control register holds the pull-up enables for two pin groups and the interrupt polarity.

Input pins pass through a two-flop synchronizer. Any level change on an unmasked input pin latches a per-pin pending flag. The interrupt pin holds its programmed active level while any flag is pending. A host read of a data register clears the flags of the pins that register covers.

The host side is a three-state machine. ST_IDLE is the state after reset, and data bytes are ignored there. A start strobe in any state moves to ST_ADDR (transition "open"). In ST_ADDR, a valid byte loads the pointer and moves to ST_DATA (transition "aim"). In ST_DATA, each valid byte is a register access and the state is held (transition "burst"). A new start strobe returns to ST_ADDR.

Top module: `gpio_expander`

## Requirements
- R1: The active-low asynchronous reset loads these values: addresses 0, 1, 2 = FF, FF, 0F; addresses 3, 4, 5 = 00; addresses 6, 7, 8 = FF, FF, 0F; address 9 = 03. Just after reset, `pin_out` is all ones, `pin_oe` is zero, `pin_pu` is all ones and `irq` is 1.
- R2: If the address byte is greater than 9, the pointer is forced to 0.
- R3: The pointer advances by one after each data byte. From 9 it wraps to 0.
- R4: Addresses 2, 5 and 8 keep only bits [3:0] of a write and read bits [7:4] as zero. Address 9 keeps bits [2:0] and reads its other bits as zero. Addresses 3, 4, 6 and 7 store all 8 bits.
- R5: Address 0 holds pins 0-7, address 1 holds pins 8-15 and address 2 holds pins 16-19 (bit n maps to pin 8·k+n). Mask registers 3-5 and direction registers 6-8 use the same grouping. A direction bit of 1 makes the pin an input (`pin_oe` low). A direction bit of 0 makes it an output (`pin_oe` high). `pin_out` shows the output latch.
- R6: Reading a data register returns the synchronized pin level for input pins and the latch value for output pins. A write changes only the latch.
- R7: Control bit 0 drives `pin_pu` for input pins 0-7. Control bit 1 drives `pin_pu` for input pins 8-19. `pin_pu` is 0 on output pins.
- R8: A level change on an unmasked input pin sets its pending flag. `irq` equals control bit 2 while any flag is pending, and equals its inverse otherwise (bit 2 = 0 means active-low).
- R9: A pin whose mask bit is 1, or which is an output, never sets a pending flag.
- R10: Reading data register k clears only the pending flags of group k.
- R11: A start strobe enters the address phase from any state. Data bytes before the first start are ignored. `hp_rdata` changes only on a read byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hp_start | input | 1 | Transaction start strobe |
| hp_valid | input | 1 | Byte strobe for address or data |
| hp_write | input | 1 | 1 = write data byte, 0 = read |
| hp_wdata | input | 8 | Address or write data byte |
| hp_rdata | output | 8 | Last read data byte |
| pin_in | input | 20 | Raw pin levels |
| pin_out | output | 20 | Output latch values |
| pin_oe | output | 20 | Output enable per pin |
| pin_pu | output | 20 | Pull-up enable per pin |
| irq | output | 1 | Interrupt, polarity programmable |

## Verification
The bench targets the pointer edges. It sends an address byte above 9, which a design without folding would store in a phantom register, and it runs a burst across address 9, which a design without wrapping would send off the end of the map. It writes full bytes to the narrow registers, so a design that stores the upper nibble reads back nonzero high bits. Interrupt tests switch the polarity, mask a group and toggle output-mode pins, so a design that skips the mask or the direction term raises a false interrupt. Reading the wrong group shows whether a design clears every flag at once instead of only the flags of the group that was read.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    localparam int PINS      = 20;
    localparam int BYTE_W    = 8;
    localparam int NREGS     = 10;
    localparam int AW        = $clog2(NREGS);
    localparam int LAST_ADDR = NREGS - 1;
    localparam int GROUPS    = (PINS + BYTE_W - 1) / BYTE_W;
    localparam int CTL_W     = 3;
    localparam int SPAN_W    = GROUPS * BYTE_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } host_st_e;

    typedef enum logic [1:0] {
        K_DATA = 2'd0,
        K_MASK = 2'd1,
        K_DIR  = 2'd2,
        K_CTL  = 2'd3
    } reg_kind_e;
endpackage

// File: rtl/gpx_host_fsm.sv
module gpx_host_fsm
    import gpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              valid,
    input  logic              write,
    input  logic [BYTE_W-1:0] wdata,
    output host_st_e          state,
    output logic [AW-1:0]     ptr,
    output logic              wr_en,
    output logic              rd_en
);
    host_st_e state_nx;
    logic     byte_take;

    assign byte_take = valid && !start;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (start) begin
            state_nx = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE: state_nx = ST_IDLE;
                ST_ADDR: if (valid) state_nx = ST_DATA;
                ST_DATA: state_nx = ST_DATA;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        wr_en = 1'b0;
        rd_en = 1'b0;
        unique case (state)
            ST_IDLE, ST_ADDR: ;
            ST_DATA: begin
                wr_en = byte_take && write;
                rd_en = byte_take && !write;
            end
            default: ;
        endcase
    end

    // address pointer: fold on load, wrap on step
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (state == ST_ADDR && byte_take) begin
            ptr <= (int'(wdata) > LAST_ADDR) ? '0 : wdata[AW-1:0];
        end else if (state == ST_DATA && byte_take) begin
            ptr <= (int'(ptr) == LAST_ADDR) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
    import gpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [AW-1:0]     addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [PINS-1:0]   pin_sync,
    output logic [PINS-1:0]   out_lat,
    output logic [PINS-1:0]   mask,
    output logic [PINS-1:0]   dir,
    output logic [CTL_W-1:0]  ctl,
    output logic [BYTE_W-1:0] rdata
);
    reg_kind_e        kind;
    logic [1:0]       grp;
    logic [PINS-1:0]  data_view;
    logic [PINS-1:0]  sel_vec;
    logic [SPAN_W-1:0] span;
    logic [BYTE_W-1:0] rd_byte;

    always_comb begin
        if (int'(addr) < GROUPS) begin
            kind = K_DATA; grp = 2'(int'(addr));
        end else if (int'(addr) < 2*GROUPS) begin
            kind = K_MASK; grp = 2'(int'(addr) - GROUPS);
        end else if (int'(addr) < 3*GROUPS) begin
            kind = K_DIR;  grp = 2'(int'(addr) - 2*GROUPS);
        end else begin
            kind = K_CTL;  grp = 2'd0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_lat <= '1;
            mask    <= '0;
            dir     <= '1;
            ctl     <= CTL_W'(3);
        end else if (wr_en) begin
            for (int i = 0; i < PINS; i++) begin
                if (int'(grp) == i / BYTE_W) begin
                    unique case (kind)
                        K_DATA: out_lat[i] <= wdata[i % BYTE_W];
                        K_MASK: mask[i]    <= wdata[i % BYTE_W];
                        K_DIR:  dir[i]     <= wdata[i % BYTE_W];
                        K_CTL:  ;
                        default: ;
                    endcase
                end
            end
            if (kind == K_CTL) ctl <= wdata[CTL_W-1:0];
        end
    end

    assign data_view = (dir & pin_sync) | (~dir & out_lat);

    always_comb begin
        unique case (kind)
            K_DATA:  sel_vec = data_view;
            K_MASK:  sel_vec = mask;
            K_DIR:   sel_vec = dir;
            default: sel_vec = '0;
        endcase
        span = SPAN_W'(sel_vec) >> (int'(grp) * BYTE_W);
        if (kind == K_CTL) rd_byte = BYTE_W'(ctl);
        else               rd_byte = span[BYTE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_byte;
    end
endmodule

// File: rtl/gpx_irq.sv
module gpx_irq
    import gpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PINS-1:0]   pin_in,
    input  logic [PINS-1:0]   dir,
    input  logic [PINS-1:0]   mask,
    input  logic [GROUPS-1:0] clr_grp,
    output logic [PINS-1:0]   pin_sync,
    output logic [PINS-1:0]   pending
);
    logic [PINS-1:0] meta, prev, hit, clr_pin;

    for (genvar i = 0; i < PINS; i++) begin : g_clr
        assign clr_pin[i] = clr_grp[i / BYTE_W];
    end

    assign hit = (pin_sync ^ prev) & dir & ~mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta     <= '0;
            pin_sync <= '0;
            prev     <= '0;
            pending  <= '0;
        end else begin
            meta     <= pin_in;
            pin_sync <= meta;
            prev     <= pin_sync;
            pending  <= hit | (pending & ~clr_pin);
        end
    end
endmodule

// File: rtl/gpio_expander.sv
module gpio_expander
    import gpx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hp_start,
    input  logic        hp_valid,
    input  logic        hp_write,
    input  logic [7:0]  hp_wdata,
    output logic [7:0]  hp_rdata,
    input  logic [19:0] pin_in,
    output logic [19:0] pin_out,
    output logic [19:0] pin_oe,
    output logic [19:0] pin_pu,
    output logic        irq
);
    host_st_e          st;
    logic [AW-1:0]     ptr;
    logic              wr_en, rd_en;
    logic [PINS-1:0]   dir, mask, pin_sync, pending;
    logic [CTL_W-1:0]  ctl;
    logic [GROUPS-1:0] clr_grp;

    gpx_host_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start(hp_start), .valid(hp_valid),
        .write(hp_write), .wdata(hp_wdata), .state(st), .ptr(ptr),
        .wr_en(wr_en), .rd_en(rd_en)
    );

    gpx_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(ptr), .wdata(hp_wdata), .pin_sync(pin_sync),
        .out_lat(pin_out), .mask(mask), .dir(dir), .ctl(ctl),
        .rdata(hp_rdata)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_grpclr
        assign clr_grp[g] = rd_en && (int'(ptr) == g);
    end

    gpx_irq u_irq (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .dir(dir),
        .mask(mask), .clr_grp(clr_grp), .pin_sync(pin_sync),
        .pending(pending)
    );

    for (genvar i = 0; i < PINS; i++) begin : g_pad
        assign pin_oe[i] = ~dir[i];
        assign pin_pu[i] = dir[i] & ctl[(i < BYTE_W) ? 0 : 1];
    end

    assign irq = (|pending) ? ctl[2] : ~ctl[2];
endmodule

// File: rtl/gpx_checker.sv
module gpx_checker
    import gpx_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          hp_start,
    input logic          hp_valid,
    input logic          hp_write,
    input logic [7:0]    hp_wdata,
    input logic [7:0]    hp_rdata,
    input logic [19:0]   pin_oe,
    input host_st_e      st,
    input logic [AW-1:0] ptr
);
    a_r2_addr_fold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ADDR && hp_valid && !hp_start && int'(hp_wdata) > LAST_ADDR) |=> (ptr == '0));

    a_r3_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && hp_valid && !hp_start && int'(ptr) == LAST_ADDR) |=> (ptr == '0));

    a_r3_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ptr) <= LAST_ADDR);

    a_r6_data_write_keeps_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && hp_valid && hp_write && !hp_start && int'(ptr) < GROUPS) |=> $stable(pin_oe));

    a_r11_rdata_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(hp_rdata) |-> $past(st == ST_DATA && hp_valid && !hp_write && !hp_start));
endmodule

bind gpio_expander gpx_checker u_chk (
    .clk(clk), .rst_n(rst_n), .hp_start(hp_start), .hp_valid(hp_valid),
    .hp_write(hp_write), .hp_wdata(hp_wdata), .hp_rdata(hp_rdata),
    .pin_oe(pin_oe), .st(st), .ptr(ptr)
);

// File: tb/gpio_expander_test.sv
module gpio_expander_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // {address, write byte, expected read-back}
    localparam logic [23:0] VECS [NVEC] = '{
        24'h03_A5_A5, 24'h05_FF_0F, 24'h08_F3_03,
        24'h09_FF_07, 24'h04_3C_3C, 24'h07_C3_C3
    };

    logic        clk = 0, rst_n = 0;
    logic        hp_start = 0, hp_valid = 0, hp_write = 0;
    logic [7:0]  hp_wdata = 0, hp_rdata;
    logic [19:0] pin_in = 0, pin_out, pin_oe, pin_pu;
    logic        irq;
    int errors = 0, checks = 0;
    bit done = 0;

    gpio_expander uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(bit s, bit v, bit w, logic [7:0] d);
        @(negedge clk);
        hp_start = s; hp_valid = v; hp_write = w; hp_wdata = d;
        @(negedge clk);
        hp_start = 0; hp_valid = 0; hp_write = 0; hp_wdata = 0;
    endtask

    task automatic open_at(logic [7:0] a);
        drive(1, 0, 0, 8'h00);
        drive(0, 1, 0, a);
    endtask

    task automatic wr(logic [7:0] d);
        drive(0, 1, 1, d);
    endtask

    task automatic rd();
        drive(0, 1, 0, 8'h00);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    initial begin
        do_reset();
        // table: write one register, read it back (R4 widths)
        for (int k = 0; k < NVEC; k++) begin
            open_at(VECS[k][23:16]);
            wr(VECS[k][15:8]);
            open_at(VECS[k][23:16]);
            rd();
            chk($sformatf("R4 table entry %0d", k), hp_rdata, VECS[k][7:0]);
        end

        // R1 reset state
        do_reset();
        chk("R1 pin_out", pin_out, 20'hFFFFF);
        chk("R1 pin_oe", pin_oe, 20'h0);
        chk("R1 pin_pu", pin_pu, 20'hFFFFF);
        chk("R1 irq", irq, 1);
        chk("R1 rdata", hp_rdata, 0);
        // R11 byte before any start is ignored
        wr(8'h00);
        chk("R11 idle byte ignored", pin_out, 20'hFFFFF);
        // R1 burst read from address 3
        begin
            logic [7:0] exp_rst [7] = '{8'h00, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'h0F, 8'h03};
            open_at(8'h03);
            for (int k = 0; k < 7; k++) begin
                rd();
                chk($sformatf("R1 reset value addr %0d", k + 3), hp_rdata, exp_rst[k]);
            end
        end
        // R2 fold of out-of-range address
        open_at(8'h3A);
        wr(8'hAA);
        chk("R2 folded write to 0", pin_out, 20'hFFFAA);
        // R3 burst wrap 8 -> 9 -> 0
        open_at(8'h08);
        wr(8'h0F); wr(8'h03); wr(8'h55);
        chk("R3 wrap write", pin_out, 20'hFFF55);
        // R5 / R7 direction and pull-ups
        open_at(8'h06);
        wr(8'h00);
        chk("R5 pin_oe", pin_oe, 20'h000FF);
        chk("R7 pu with ctl=3", pin_pu, 20'hFFF00);
        open_at(8'h09);
        wr(8'h01);
        chk("R7 pu with ctl=1", pin_pu, 20'h00000);
        open_at(8'h09);
        wr(8'h03);
        // R6 / R8 / R10 read views and pending
        open_at(8'h00);
        wr(8'h5A);
        chk("R5 pin_out latch", pin_out, 20'hFFF5A);
        pin_in = 20'h0C3A5;
        settle();
        chk("R8 irq active low", irq, 0);
        open_at(8'h00);
        rd();
        chk("R6 output pins read latch", hp_rdata, 8'h5A);
        chk("R10 other group not cleared", irq, 0);
        rd();
        chk("R6 input pins read level", hp_rdata, 8'hC3);
        chk("R10 group cleared", irq, 1);
        // R9 masked group and output pins
        open_at(8'h04);
        wr(8'hFF);
        pin_in = 20'h000FF;
        settle();
        chk("R9 masked/output no irq", irq, 1);
        // R8 polarity high
        open_at(8'h09);
        wr(8'h07);
        chk("R8 idle high polarity", irq, 0);
        open_at(8'h04);
        wr(8'h00);
        pin_in = 20'h002FF;
        settle();
        chk("R8 irq active high", irq, 1);
        open_at(8'h01);
        rd();
        chk("R6 group1 read", hp_rdata, 8'h02);
        chk("R10 clear group1", irq, 0);
        pin_in = 20'h102FF;
        settle();
        chk("R8 group2 pin", irq, 1);
        open_at(8'h02);
        rd();
        chk("R4 group2 upper zero", hp_rdata, 8'h01);
        chk("R10 clear group2", irq, 0);
        open_at(8'h03);
        wr(8'h00);
        chk("R11 rdata held on write", hp_rdata, 8'h01);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule